// File: doc/BRIEF.md
# Two-Wire Token Card Command Decoder

This block sits between the two strobe inputs of a synchronous token card and the card's memory and access logic. One input is a command line and the other is an execution clock. The block watches the pulse patterns on the two lines and keeps a bit address into a 276-bit memory map. It reports each recognised command as a one-cycle opcode strobe. It also drives the open-drain serial data line, which carries read data, the busy/done handshake during programming and the released state in the key area.

A command is set by the number of command-line pulses that come before a clock pulse, and by whether the two lines are high together. The same pattern means different things at different addresses. For example, a second write sequence becomes a nibble erase, a byte erase or a digit carry depending on the area. A double pulse becomes a signature start, a test-mode entry or a combined decrement-and-erase.

The access logic supplies a per-address write permission. The memory supplies the bit at the current address. Non-volatile programming time is modelled by a parameterised cycle counter, and the power-on hold time is modelled the same way.

Top module: `token_cmd_decoder`

## Requirements
- R1: After the synchronous reset input, the data line is driven low (dq_oe=1, dq_out=0) for POR_CYCLES cycles. Line activity in that window has no effect: the address stays 0.
- R2: A clock pulse with no command pulse before it is a read. On the clock rise the address steps by one and op_code 1 is strobed. On the clock fall the data line drives the memory bit at the new address (dq_oe=1, dq_out=mem_rdata).
- R3: Command and clock high together is a reset. It sets the address to 0, clears test_mode and strobes op_code 0, and no read takes place. Once both lines are low, the line shows the bit at address 0.
- R4: A read at address ADDR_LAST (275) moves the address to 0.
- R5: One command pulse and then a clock pulse, with wr_ok high, is a bit write (op_code 3).
- R6: A memory-modifying command (op_code 3 to 7) drives the line high (dq_oe=1, dq_out=1) from its decision cycle. The line goes low PROG_CYCLES+1 cycles later, once the clock is low. Pulses on either line in between are ignored.
- R7: A single-pulse sequence directly after a performed bit write is an erase, chosen by address. Addresses 65–103 give op_code 4 (digit carry), 108–115 give op_code 5 (nibble) and 116–211 give op_code 6 (byte). Any other address gives op_code 2.
- R8: A modifying command without wr_ok is turned into a read in place (op_code 2). The address does not move, and the clock fall drives the current memory bit.
- R9: Commands that can modify memory never change the address, even when they are turned into reads.
- R10: Two command pulses and then a clock pulse form an extended command. At 259 it is op_code 8. At 163 it is op_code 9 and sets test_mode. In 65–103 it is op_code 7, and elsewhere it is a bit write (op_code 3). Both op_code 7 and the bit write need wr_ok, otherwise op_code 2.
- R11: A read that moves the address into 148–211 releases the line (dq_oe=0) in the same cycle the address changes. The line stays released at the clock fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cmd_in | input | 1 | Command line level |
| sck_in | input | 1 | Execution clock line level |
| wr_ok | input | 1 | Access logic permits modification at the current address |
| mem_rdata | input | 1 | Memory bit at the current address |
| addr | output | ADDR_W | Current bit address |
| op_valid | output | 1 | One-cycle strobe for a decoded command |
| op_code | output | 4 | Decoded command code (see R2–R10) |
| test_mode | output | 1 | Test mode entered, cleared by line reset |
| dq_oe | output | 1 | Data line output enable (0 = released) |
| dq_out | output | 1 | Data line value while enabled |

## Verification
Long runs of bare clock pulses check address stepping, the wrap at 275 and the release in the key area. Single, double and repeated single command pulses at addresses in the serial, digit, nibble, byte, key, test and signature areas show that decoding depends on both pulse count and address. The same patterns are repeated with wr_ok low to tell a real write apart from one turned into a read. Extra pulses sent while programming, and during the power-on hold, confirm that only the handshake moves the line in those windows.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  typedef enum logic [3:0] {
    OP_RESET     = 4'd0,
    OP_READ      = 4'd1,
    OP_STAY      = 4'd2,
    OP_BITWR     = 4'd3,
    OP_ERS_DIGIT = 4'd4,
    OP_ERS_NIB   = 4'd5,
    OP_ERS_BYTE  = 4'd6,
    OP_DECERS    = 4'd7,
    OP_SIGN      = 4'd8,
    OP_TEST      = 4'd9
  } tcd_op_e;

  typedef enum logic [1:0] {
    ST_POR,
    ST_IDLE,
    ST_OVL,
    ST_BUSY
  } tcd_state_e;

  function automatic logic op_writes(input tcd_op_e op);
    return (op == OP_BITWR) || (op == OP_ERS_DIGIT) || (op == OP_ERS_NIB) ||
           (op == OP_ERS_BYTE) || (op == OP_DECERS);
  endfunction

endpackage

// File: rtl/tcd_line_sync.sv
module tcd_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic cmd_in,
  input  logic sck_in,
  output logic cmd_lvl,
  output logic sck_lvl,
  output logic cmd_fall,
  output logic sck_rise,
  output logic sck_fall
);
  // two registered stages per line: index 0 = command, 1 = clock
  logic [1:0] stg1;
  logic [1:0] stg2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= {sck_in, cmd_in};
      stg2 <= stg1;
    end
  end

  assign cmd_lvl  = stg1[0];
  assign sck_lvl  = stg1[1];
  assign cmd_fall = ~stg1[0] & stg2[0];
  assign sck_rise = stg1[1] & ~stg2[1];
  assign sck_fall = ~stg1[1] & stg2[1];
endmodule

// File: rtl/tcd_addr_ctr.sv
module tcd_addr_ctr #(
  parameter int ADDR_W    = 9,
  parameter int ADDR_LAST = 275
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ADDR_LAST);

  assign nxt = (addr == LAST) ? '0 : addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (inc)   addr <= nxt;
  end
endmodule

// File: rtl/tcd_timer.sv
module tcd_timer #(
  parameter int W    = 8,
  parameter int INIT = 0,
  parameter int LOAD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(INIT);
    else if (load)        cnt <= W'(LOAD);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/tcd_decode.sv
module tcd_decode
  import tcd_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DIGIT_LO  = 65,
  parameter int DIGIT_HI  = 103,
  parameter int NIB_LO    = 108,
  parameter int NIB_HI    = 115,
  parameter int BYTE_LO   = 116,
  parameter int KEY_HI    = 211,
  parameter int TEST_ADDR = 163,
  parameter int SIGN_ADDR = 259
) (
  input  logic [1:0]        pend,
  input  logic              pair,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_ok,
  output tcd_op_e           op
);
  localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(DIGIT_LO);
  localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(DIGIT_HI);
  localparam logic [ADDR_W-1:0] A_NLO  = ADDR_W'(NIB_LO);
  localparam logic [ADDR_W-1:0] A_NHI  = ADDR_W'(NIB_HI);
  localparam logic [ADDR_W-1:0] A_BLO  = ADDR_W'(BYTE_LO);
  localparam logic [ADDR_W-1:0] A_BHI  = ADDR_W'(KEY_HI);
  localparam logic [ADDR_W-1:0] A_TST  = ADDR_W'(TEST_ADDR);
  localparam logic [ADDR_W-1:0] A_SIG  = ADDR_W'(SIGN_ADDR);

  logic in_dig, in_nib, in_byte;

  always_comb begin
    in_dig  = (addr >= A_DLO) && (addr <= A_DHI);
    in_nib  = (addr >= A_NLO) && (addr <= A_NHI);
    in_byte = (addr >= A_BLO) && (addr <= A_BHI);
    op      = OP_STAY;
    case (pend)
      2'd0: op = OP_READ;
      2'd1: begin
        if (!pair)        op = wr_ok ? OP_BITWR : OP_STAY;
        else if (!wr_ok)  op = OP_STAY;
        else if (in_dig)  op = OP_ERS_DIGIT;
        else if (in_nib)  op = OP_ERS_NIB;
        else if (in_byte) op = OP_ERS_BYTE;
        else              op = OP_STAY;
      end
      default: begin
        if (addr == A_SIG)      op = OP_SIGN;
        else if (addr == A_TST) op = OP_TEST;
        else if (!wr_ok)        op = OP_STAY;
        else if (in_dig)        op = OP_DECERS;
        else                    op = OP_BITWR;
      end
    endcase
  end
endmodule

// File: rtl/token_cmd_decoder.sv
module token_cmd_decoder
  import tcd_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int ADDR_LAST   = 275,
  parameter int POR_CYCLES  = 64,
  parameter int PROG_CYCLES = 200,
  parameter int DIGIT_LO    = 65,
  parameter int DIGIT_HI    = 103,
  parameter int NIB_LO      = 108,
  parameter int NIB_HI      = 115,
  parameter int BYTE_LO     = 116,
  parameter int KEY_LO      = 148,
  parameter int KEY_HI      = 211,
  parameter int TEST_ADDR   = 163,
  parameter int SIGN_ADDR   = 259
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_in,
  input  logic              sck_in,
  input  logic              wr_ok,
  input  logic              mem_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic              test_mode,
  output logic              dq_oe,
  output logic              dq_out
);
  localparam int POR_W = $clog2(POR_CYCLES + 1);
  localparam int PRG_W = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_KLO = ADDR_W'(KEY_LO);
  localparam logic [ADDR_W-1:0] A_KHI = ADDR_W'(KEY_HI);

  function automatic logic in_key(input logic [ADDR_W-1:0] a);
    return (a >= A_KLO) && (a <= A_KHI);
  endfunction

  logic cmd_lvl, sck_lvl, cmd_fall, sck_rise, sck_fall;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic addr_clr, addr_inc, prog_start, por_done, prog_done;
  logic ovl_fire, dec_fire;
  logic [1:0] pend;
  logic pair;
  tcd_op_e dec_op;
  tcd_state_e state;

  tcd_line_sync u_sync (
    .clk(clk), .rst(rst), .cmd_in(cmd_in), .sck_in(sck_in),
    .cmd_lvl(cmd_lvl), .sck_lvl(sck_lvl), .cmd_fall(cmd_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  tcd_addr_ctr #(.ADDR_W(ADDR_W), .ADDR_LAST(ADDR_LAST)) u_addr (
    .clk(clk), .rst(rst), .clr(addr_clr), .inc(addr_inc),
    .addr(addr_q), .nxt(addr_nxt)
  );

  tcd_timer #(.W(POR_W), .INIT(POR_CYCLES), .LOAD(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .load(1'b0), .done(por_done)
  );

  tcd_timer #(.W(PRG_W), .INIT(0), .LOAD(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .load(prog_start), .done(prog_done)
  );

  tcd_decode #(
    .ADDR_W(ADDR_W), .DIGIT_LO(DIGIT_LO), .DIGIT_HI(DIGIT_HI),
    .NIB_LO(NIB_LO), .NIB_HI(NIB_HI), .BYTE_LO(BYTE_LO), .KEY_HI(KEY_HI),
    .TEST_ADDR(TEST_ADDR), .SIGN_ADDR(SIGN_ADDR)
  ) u_dec (
    .pend(pend), .pair(pair), .addr(addr_q), .wr_ok(wr_ok), .op(dec_op)
  );

  // overlap of both lines wins over any edge seen in the same cycle
  always_comb begin
    ovl_fire   = (state == ST_IDLE) && cmd_lvl && sck_lvl;
    dec_fire   = (state == ST_IDLE) && !ovl_fire && !cmd_fall && sck_rise;
    addr_clr   = ovl_fire;
    addr_inc   = dec_fire && (dec_op == OP_READ);
    prog_start = dec_fire && op_writes(dec_op);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_POR;
      pend      <= '0;
      pair      <= 1'b0;
      test_mode <= 1'b0;
      op_valid  <= 1'b0;
      op_code   <= 4'(OP_RESET);
      dq_oe     <= 1'b1;
      dq_out    <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      case (state)
        ST_POR: if (por_done) state <= ST_IDLE;
        ST_IDLE: begin
          if (ovl_fire) begin
            state     <= ST_OVL;
            pend      <= '0;
            pair      <= 1'b0;
            test_mode <= 1'b0;
            op_valid  <= 1'b1;
            op_code   <= 4'(OP_RESET);
          end else if (cmd_fall) begin
            pend <= (pend == 2'd2) ? 2'd2 : pend + 1'b1;
          end else if (sck_rise) begin
            pend     <= '0;
            op_valid <= 1'b1;
            op_code  <= 4'(dec_op);
            pair     <= (dec_op == OP_BITWR);
            if (dec_op == OP_TEST) test_mode <= 1'b1;
            if (op_writes(dec_op)) begin
              state  <= ST_BUSY;
              dq_oe  <= 1'b1;
              dq_out <= 1'b1;
            end else if ((dec_op == OP_READ) && in_key(addr_nxt)) begin
              dq_oe <= 1'b0;
            end
          end else if (sck_fall) begin
            dq_oe  <= !in_key(addr_q);
            dq_out <= mem_rdata;
          end
        end
        ST_OVL: begin
          if (!cmd_lvl && !sck_lvl) begin
            state  <= ST_IDLE;
            dq_oe  <= !in_key(addr_q);
            dq_out <= mem_rdata;
          end
        end
        default: begin
          if (prog_done && !sck_lvl) begin
            state  <= ST_IDLE;
            dq_oe  <= 1'b1;
            dq_out <= 1'b0;
          end
        end
      endcase
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker
  import tcd_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int ADDR_LAST = 275,
  parameter int KEY_LO    = 148,
  parameter int KEY_HI    = 211
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic              test_mode,
  input logic              dq_oe,
  input logic              dq_out
);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(ADDR_LAST);
  localparam logic [ADDR_W-1:0] A_KLO  = ADDR_W'(KEY_LO);
  localparam logic [ADDR_W-1:0] A_KHI  = ADDR_W'(KEY_HI);

  AST_POR_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dq_oe && !dq_out)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |-> (addr == '0 || addr == $past(addr) + 1'b1)); // R2

  AST_LINE_RESET: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'(OP_RESET)) |-> (addr == '0 && !test_mode)); // R3

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (addr == A_LAST) |=> (addr == A_LAST || addr == '0)); // R4

  AST_BUSY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 4'(OP_BITWR) && op_code <= 4'(OP_DECERS))
      |-> (dq_oe && dq_out)); // R6

  AST_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 4'(OP_STAY)) |-> (addr == $past(addr))); // R9

  AST_TEST_SET: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'(OP_TEST)) |-> test_mode); // R10

  AST_KEY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'(OP_READ) && addr >= A_KLO && addr <= A_KHI)
      |-> !dq_oe); // R11
endmodule

bind token_cmd_decoder tcd_checker #(
  .ADDR_W(ADDR_W), .ADDR_LAST(ADDR_LAST), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .op_valid(op_valid), .op_code(op_code),
  .test_mode(test_mode), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/token_cmd_decoder_test.sv
module token_cmd_decoder_test;
  localparam int POR  = 20;
  localparam int PROG = 20;
  localparam int LAST = 275;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_in = 1'b0, sck_in = 1'b0, wr_ok = 1'b1;
  logic mem_rdata;
  logic [8:0] addr;
  logic op_valid, test_mode, dq_oe, dq_out;
  logic [3:0] op_code;

  int n_chk = 0, n_fail = 0, last_op = -1;
  bit armed = 0, reported = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  function automatic bit mem_bit(input int a);
    return ((a * 5 + 3) % 7) < 3;
  endfunction

  assign mem_rdata = mem_bit(int'(addr));

  token_cmd_decoder #(.POR_CYCLES(POR), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst(rst), .cmd_in(cmd_in), .sck_in(sck_in), .wr_ok(wr_ok),
    .mem_rdata(mem_rdata), .addr(addr), .op_valid(op_valid), .op_code(op_code),
    .test_mode(test_mode), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  // ---------------- behavioural reference ----------------
  int m_st, m_por, m_prog, m_c1, m_c2, m_k1, m_k2, m_pend, m_pair, m_test;
  int m_addr, m_oe, m_out, m_v, m_op;

  function automatic bit key_area(input int a);
    return a >= 148 && a <= 211;
  endfunction

  function automatic int ref_op(input int pend, input int pair, input int a, input int ok);
    bit dig = (a >= 65 && a <= 103);
    if (pend == 0) return 1;
    if (pend == 1) begin
      if (pair == 0) return ok ? 3 : 2;
      if (!ok) return 2;
      if (dig) return 4;
      if (a >= 108 && a <= 115) return 5;
      if (a >= 116 && a <= 211) return 6;
      return 2;
    end
    if (a == 259) return 8;
    if (a == 163) return 9;
    if (!ok) return 2;
    return dig ? 7 : 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_por = POR; m_prog = 0; m_c1 = 0; m_c2 = 0; m_k1 = 0; m_k2 = 0;
      m_pend = 0; m_pair = 0; m_test = 0; m_addr = 0; m_oe = 1; m_out = 0;
      m_v = 0; m_op = 0;
    end else begin
      int n_por, n_prog, op;
      bit cf, kr, kf;
      cf = (m_c1 == 0) && (m_c2 == 1);
      kr = (m_k1 == 1) && (m_k2 == 0);
      kf = (m_k1 == 0) && (m_k2 == 1);
      n_por  = (m_por > 0) ? m_por - 1 : 0;
      n_prog = (m_prog > 0) ? m_prog - 1 : 0;
      m_v = 0;
      if (m_st == 0) begin
        if (m_por == 0) m_st = 1;
      end else if (m_st == 1) begin
        if (m_c1 == 1 && m_k1 == 1) begin
          m_st = 2; m_addr = 0; m_pend = 0; m_pair = 0; m_test = 0; m_v = 1; m_op = 0;
        end else if (cf) begin
          if (m_pend < 2) m_pend++;
        end else if (kr) begin
          op = ref_op(m_pend, m_pair, m_addr, int'(wr_ok));
          m_pend = 0; m_v = 1; m_op = op; m_pair = (op == 3);
          if (op == 9) m_test = 1;
          if (op >= 3 && op <= 7) begin
            m_st = 3; m_oe = 1; m_out = 1; n_prog = PROG;
          end else if (op == 1) begin
            m_addr = (m_addr == LAST) ? 0 : m_addr + 1;
            if (key_area(m_addr)) m_oe = 0;
          end
        end else if (kf) begin
          m_oe = key_area(m_addr) ? 0 : 1; m_out = mem_bit(m_addr);
        end
      end else if (m_st == 2) begin
        if (m_c1 == 0 && m_k1 == 0) begin
          m_st = 1; m_oe = key_area(m_addr) ? 0 : 1; m_out = mem_bit(m_addr);
        end
      end else begin
        if (m_prog == 0 && m_k1 == 0) begin
          m_st = 1; m_oe = 1; m_out = 0;
        end
      end
      m_c2 = m_c1; m_c1 = int'(cmd_in); m_k2 = m_k1; m_k1 = int'(sck_in);
      m_por = n_por; m_prog = n_prog;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(cur_req, "addr", int'(addr), m_addr);
      chk(cur_req, "dq_oe", int'(dq_oe), m_oe);
      chk(cur_req, "dq_out", int'(dq_out), m_out);
      chk(cur_req, "test_mode", int'(test_mode), m_test);
      chk(cur_req, "op_valid", int'(op_valid), m_v);
      if (m_v == 1) chk(cur_req, "op_code", int'(op_code), m_op);
    end
    if (op_valid === 1'b1) last_op = int'(op_code);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      sck_in = 1'b1; tick(3); sck_in = 1'b0; tick(3);
    end
  endtask

  task automatic cmd_pulse();
    cmd_in = 1'b1; tick(3); cmd_in = 1'b0; tick(3);
  endtask

  task automatic mod_cmd(input int npulse, input bit ok);
    wr_ok = ok;
    for (int i = 0; i < npulse; i++) cmd_pulse();
    sck_in = 1'b1; tick(3); sck_in = 1'b0; tick(PROG + 6);
    wr_ok = 1'b1;
  endtask

  task automatic line_reset();
    cmd_in = 1'b1; tick(3); sck_in = 1'b1; tick(3);
    cmd_in = 1'b0; tick(3); sck_in = 1'b0; tick(3);
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    tick(3);
    armed = 1;
    chk("R1", "reset addr", int'(addr), 0);
    chk("R1", "reset line low", int'(dq_oe && !dq_out), 1);
    rst = 1'b0;
    cur_req = "R1";
    tick(2);
    sck_in = 1'b1; tick(3); sck_in = 1'b0; tick(3);
    chk("R1", "read ignored in hold", int'(addr), 0);
    chk("R1", "line held low", int'(dq_oe && !dq_out), 1);
    tick(POR + 4);

    cur_req = "R2";
    read_n(5);
    chk("R2", "addr after 5 reads", int'(addr), 5);
    chk("R2", "line shows bit", int'(dq_out), int'(mem_bit(5)));
    chk("R2", "last op read", last_op, 1);

    cur_req = "R3";
    line_reset();
    chk("R3", "addr cleared", int'(addr), 0);
    chk("R3", "reset opcode", last_op, 0);
    chk("R3", "line shows bit 0", int'(dq_out), int'(mem_bit(0)));

    cur_req = "R5";
    read_n(30);
    mod_cmd(1, 1'b1);
    chk("R5", "bit write opcode", last_op, 3);
    cur_req = "R7";
    mod_cmd(1, 1'b1);
    chk("R7", "erase outside areas", last_op, 2);
    chk("R9", "addr kept", int'(addr), 30);

    cur_req = "R10";
    read_n(10);
    mod_cmd(2, 1'b1);
    chk("R10", "extended acts as bit write", last_op, 3);

    cur_req = "R8";
    read_n(30);
    mod_cmd(1, 1'b0);
    chk("R8", "denied write turned into read", last_op, 2);
    chk("R8", "line shows current bit", int'(dq_out), int'(mem_bit(70)));
    cur_req = "R7";
    mod_cmd(1, 1'b1);
    mod_cmd(1, 1'b1);
    chk("R7", "digit carry erase", last_op, 4);
    chk("R9", "addr kept in digit area", int'(addr), 70);
    cur_req = "R10";
    mod_cmd(2, 1'b1);
    chk("R10", "decrement erase", last_op, 7);
    mod_cmd(2, 1'b0);
    chk("R10", "denied decrement erase", last_op, 2);

    cur_req = "R6";
    read_n(2);
    wr_ok = 1'b1;
    cmd_pulse();
    sck_in = 1'b1; tick(4);
    chk("R6", "busy line high", int'(dq_oe && dq_out), 1);
    sck_in = 1'b0; tick(2);
    sck_in = 1'b1; tick(2); sck_in = 1'b0; tick(1);
    cmd_pulse();
    chk("R6", "still busy", int'(dq_oe && dq_out), 1);
    chk("R6", "pulses ignored", int'(addr), 72);
    tick(PROG + 6);
    chk("R6", "done line low", int'(dq_oe && !dq_out), 1);
    chk("R6", "opcode unchanged", last_op, 3);
    read_n(1);
    chk("R6", "pulse in busy not counted", last_op, 1);

    cur_req = "R7";
    read_n(37);
    mod_cmd(1, 1'b1); mod_cmd(1, 1'b1);
    chk("R7", "nibble erase", last_op, 5);
    read_n(10);
    mod_cmd(1, 1'b1); mod_cmd(1, 1'b1);
    chk("R7", "byte erase", last_op, 6);

    cur_req = "R11";
    read_n(27);
    chk("R11", "addr 147", int'(addr), 147);
    sck_in = 1'b1; tick(3);
    chk("R11", "released on entry", int'(dq_oe), 0);
    sck_in = 1'b0; tick(3);
    chk("R11", "released after fall", int'(dq_oe), 0);

    cur_req = "R10";
    read_n(15);
    mod_cmd(2, 1'b1);
    chk("R10", "test entry opcode", last_op, 9);
    chk("R10", "test mode set", int'(test_mode), 1);

    cur_req = "R7";
    read_n(37);
    mod_cmd(1, 1'b1); mod_cmd(1, 1'b1);
    chk("R7", "key byte erase", last_op, 6);

    cur_req = "R10";
    read_n(59);
    mod_cmd(2, 1'b0);
    chk("R10", "signature start", last_op, 8);

    cur_req = "R4";
    read_n(16);
    chk("R4", "addr at top", int'(addr), LAST);
    read_n(1);
    chk("R4", "wrap to zero", int'(addr), 0);

    cur_req = "R3";
    line_reset();
    chk("R3", "test mode cleared", int'(test_mode), 0);
    chk("R3", "addr zero", int'(addr), 0);
    tick(4);
    finish_run();
  end
endmodule